// File: doc/BRIEF.md
# Serially Configured Two-Table Logic Tile

This block is a very small programmable logic tile. Two lookup tables each take three address bits and return two data bits, so every table holds two independent three-input Boolean functions. A four-input, two-output routing mux sits between the tables. Every table output has a flip-flop, and a per-output bypass choice decides whether the tile pin shows the registered value or the combinational one. The truth tables, the routing and the bypass choices all come from one 40-bit configuration shift register. That register is loaded one bit at a time on a serial data pin, with a dedicated configuration clock, while a load-enable input is high.

The first table is addressed directly by three external pins. The second table takes its two low address bits from the routing mux outputs and its top bit from one external pin. The routing mux can choose either output of the first table or either flip-flop of the second table. This lets the tile build wide combinational functions, and it also lets it build small state machines whose state lives in the second table's flip-flops.

Top module: `fab_tile`

## Requirements
- R1: On each rising edge of `cfg_clk` with `cfg_en` high, `cfg_din` enters the chain and every chain bit moves one place toward the start. With `cfg_en` low, `cfg_clk` edges leave the configuration unchanged. After 40 loading edges, the bit shifted in at step k (counted from 0) is held at stream position k.
- R2: Stream positions 0 to 15 hold table A, with word w at positions 2w (output 0) and 2w+1 (output 1). Positions 16 and 17 hold the select for route 0, positions 18 and 19 hold the select for route 1, positions 20 to 35 hold table B in the same word layout, and positions 36 to 39 hold the register-select bits for tile outputs 0 to 3. A 2-bit select is streamed low bit first, so the value 2'b10 is shifted as 0 and then 1.
- R3: Table A's address is `lut_a_in` (bit 2 is the most significant bit). Its word bit 0 drives tile output 0 and its word bit 1 drives tile output 1.
- R4: Route select value 0 picks tile output 0, value 1 picks tile output 1, value 2 picks table B's output-0 flip-flop, and value 3 picks table B's output-1 flip-flop.
- R5: Table B's address is {`lut_b_in`, route 1, route 0}. Its word bit 0 drives tile output 2 and its word bit 1 drives tile output 3.
- R6: When an output's register-select bit is 1, the output shows a flip-flop that captures the table bit on every rising `clk` edge. When the bit is 0, the output follows the table bit combinationally.
- R7: `rst` high at a rising `clk` edge clears all four flip-flops to 0. Combinational outputs are not affected.
- R8: While `cfg_en` is high, all tile outputs are 0 and the flip-flops are cleared at every `clk` edge. After a reload, state therefore restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock for the output flip-flops |
| rst | input | 1 | Synchronous active-high clear of the flip-flops |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_en | input | 1 | Load enable; holds outputs low while high |
| cfg_din | input | 1 | Serial configuration data |
| lut_a_in | input | 3 | Address of table A |
| lut_b_in | input | 1 | Top address bit of table B |
| tile_out | output | 4 | Tile outputs: 1:0 from table A, 3:2 from table B |

## Verification
Assertions are checked on every cycle for the following: the chain holds still when loading is disabled, and it takes in the serial bit when loading is enabled; outputs stay at zero during a load, and the flip-flops are empty after one; a registered output equals the table bit from one clock earlier, and a bypassed output equals the current table bit; the flip-flops are clear after reset. Some behaviour can only be shown by the bench scenarios, because it depends on a whole loaded image: that the field placement and the low-bit-first select order are right, that a decoder, a gated function and a counter load and work as intended, that ignored configuration pulses change nothing, and that a reload restarts the counter.

// File: rtl/fab_pkg.sv
package fab_pkg;

    localparam int LUT_IN    = 3;
    localparam int LUT_OUT   = 2;
    localparam int LUT_WORDS = 1 << LUT_IN;
    localparam int LUT_BITS  = LUT_WORDS * LUT_OUT;
    localparam int SW_IN     = 4;
    localparam int SW_OUT    = 2;
    localparam int SW_SEL_W  = $clog2(SW_IN);
    localparam int NUM_LUT   = 2;
    localparam int TILE_OUTS = NUM_LUT * LUT_OUT;
    localparam int B_EXT     = LUT_IN - SW_OUT;
    localparam int CHAIN_LEN = NUM_LUT * LUT_BITS + SW_OUT * SW_SEL_W + TILE_OUTS;

    typedef logic [LUT_IN-1:0]   lut_addr_t;
    typedef logic [LUT_OUT-1:0]  lut_word_t;
    typedef logic [LUT_BITS-1:0] lut_image_t;
    typedef logic [SW_SEL_W-1:0] sw_sel_t;

    // Packed so that the lowest stream position lands in the lowest bit.
    typedef struct packed {
        logic [TILE_OUTS-1:0]   reg_sel;
        lut_image_t             lut_b;
        sw_sel_t [SW_OUT-1:0]   route;
        lut_image_t             lut_a;
    } tile_cfg_t;

    function automatic lut_word_t lut_lookup(input lut_image_t img, input lut_addr_t addr);
        return img[int'(addr) * LUT_OUT +: LUT_OUT];
    endfunction

endpackage

// File: rtl/fab_cfg_chain.sv
module fab_cfg_chain
    import fab_pkg::*;
(
    input  logic                 cfg_clk,
    input  logic                 rst,
    input  logic                 cfg_en,
    input  logic                 cfg_din,
    output logic [CHAIN_LEN-1:0] chain_q
);

    // New bits enter at the far end and walk toward position 0.
    always_ff @(posedge cfg_clk) begin
        if (cfg_en) begin
            chain_q <= {cfg_din, chain_q[CHAIN_LEN-1:1]};
        end
    end

    assert_hold_R1: assert property (@(posedge cfg_clk) disable iff (rst)
        !cfg_en |=> $stable(chain_q))
        else $error("configuration changed without load enable");

    assert_entry_R1: assert property (@(posedge cfg_clk) disable iff (rst)
        cfg_en |=> (chain_q[CHAIN_LEN-1] == $past(cfg_din)))
        else $error("serial bit did not enter the chain");

endmodule

// File: rtl/fab_lut.sv
module fab_lut
    import fab_pkg::*;
(
    input  lut_image_t image,
    input  lut_addr_t  addr,
    output lut_word_t  data
);

    always_comb begin
        data = lut_lookup(image, addr);
    end

endmodule

// File: rtl/fab_switch.sv
module fab_switch
    import fab_pkg::*;
(
    input  logic [SW_IN-1:0]    sw_in,
    input  sw_sel_t [SW_OUT-1:0] sel,
    output logic [SW_OUT-1:0]   sw_out
);

    always_comb begin
        for (int j = 0; j < SW_OUT; j++) begin
            sw_out[j] = sw_in[sel[j]];
        end
    end

endmodule

// File: rtl/fab_out_stage.sv
module fab_out_stage
    import fab_pkg::*;
#(
    parameter int W = LUT_OUT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_en,
    input  logic [W-1:0] lut_val,
    input  logic [W-1:0] reg_sel,
    output logic [W-1:0] ff_q,
    output logic [W-1:0] out_q
);

    always_ff @(posedge clk) begin
        if (rst || cfg_en) begin
            ff_q <= '0;
        end else begin
            ff_q <= lut_val;
        end
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign out_q[i] = cfg_en ? 1'b0 : (reg_sel[i] ? ff_q[i] : lut_val[i]);

            assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
                (reg_sel[i] && !cfg_en && !$past(cfg_en) && !$past(rst))
                    |-> (out_q[i] == $past(lut_val[i])))
                else $error("registered output lost its captured value");

            assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
                (!reg_sel[i] && !cfg_en) |-> (out_q[i] == lut_val[i]))
                else $error("bypassed output differs from table bit");
        end
    endgenerate

    assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> (out_q == '0))
        else $error("output active during load");

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ff_q == '0))
        else $error("flip-flops not cleared by reset");

endmodule

// File: rtl/fab_tile.sv
module fab_tile
    import fab_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_clk,
    input  logic                 cfg_en,
    input  logic                 cfg_din,
    input  logic [LUT_IN-1:0]    lut_a_in,
    input  logic [B_EXT-1:0]     lut_b_in,
    output logic [TILE_OUTS-1:0] tile_out
);

    logic [CHAIN_LEN-1:0] chain_q;
    tile_cfg_t            cfg;
    lut_word_t            a_raw, b_raw;
    lut_word_t            a_out, b_out;
    lut_word_t            a_ff, b_ff;
    logic [SW_IN-1:0]     sw_in;
    logic [SW_OUT-1:0]    route;
    lut_addr_t            b_addr;

    fab_cfg_chain u_chain (
        .cfg_clk (cfg_clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .chain_q (chain_q)
    );

    assign cfg = tile_cfg_t'(chain_q);

    fab_lut u_lut_a (
        .image (cfg.lut_a),
        .addr  (lut_a_in),
        .data  (a_raw)
    );

    fab_out_stage #(.W(LUT_OUT)) u_stage_a (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .lut_val (a_raw),
        .reg_sel (cfg.reg_sel[LUT_OUT-1:0]),
        .ff_q    (a_ff),
        .out_q   (a_out)
    );

    // Routing candidates: both A outputs, then both B flip-flops.
    assign sw_in = {b_ff, a_out};

    fab_switch u_switch (
        .sw_in  (sw_in),
        .sel    (cfg.route),
        .sw_out (route)
    );

    assign b_addr = {lut_b_in, route};

    fab_lut u_lut_b (
        .image (cfg.lut_b),
        .addr  (b_addr),
        .data  (b_raw)
    );

    fab_out_stage #(.W(LUT_OUT)) u_stage_b (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .lut_val (b_raw),
        .reg_sel (cfg.reg_sel[TILE_OUTS-1:LUT_OUT]),
        .ff_q    (b_ff),
        .out_q   (b_out)
    );

    assign tile_out = {b_out, a_out};

    assert_held_R8: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_en) |-> ((a_ff == '0) && (b_ff == '0)))
        else $error("state survived a configuration load");

endmodule

// File: tb/fab_tile_tb_top.sv
module fab_tile_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_clk = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [2:0] in_a = 3'd0;
    logic [0:0] in_b = 1'b0;
    logic [3:0] tout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fab_tile dut_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_clk  (cfg_clk),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .lut_a_in (in_a),
        .lut_b_in (in_b),
        .tile_out (tout)
    );

    // Decoder vectors: {lut_a_in, expected tile_out}; lut_b_in is driven with lut_a_in[0].
    localparam logic [6:0] DEC_VEC [8] = '{
        7'b000_0001, 7'b001_0010, 7'b010_0100, 7'b011_1000,
        7'b100_0001, 7'b101_0010, 7'b110_0100, 7'b111_1000
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_img(input logic [7:0] t0, input logic [7:0] t1);
        logic [15:0] img;
        for (int w = 0; w < 8; w++) begin
            img[2*w]   = t0[w];
            img[2*w+1] = t1[w];
        end
        return img;
    endfunction

    function automatic logic [39:0] mk_stream(input logic [15:0] la, input logic [1:0] r0,
                                              input logic [1:0] r1, input logic [15:0] lb,
                                              input logic [3:0] rs);
        logic [39:0] s;
        s[15:0]  = la;
        s[16]    = r0[0];
        s[17]    = r0[1];
        s[18]    = r1[0];
        s[19]    = r1[1];
        s[35:20] = lb;
        s[39:36] = rs;
        return s;
    endfunction

    function automatic logic par3(input logic [2:0] v);
        return ^v;
    endfunction

    function automatic logic maj3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

    task automatic load(input logic [39:0] s);
        @(negedge clk);
        cfg_en = 1'b1;
        for (int k = 0; k < 40; k++) begin
            cfg_din = s[k];
            #3 cfg_clk = 1'b1;
            #3 cfg_clk = 1'b0;
            if (k == 20) chk("R8 outputs low while loading", tout, 4'b0000);
        end
        #2 cfg_en = 1'b0;
        cfg_din = 1'b0;
        @(negedge clk);
    endtask

    task automatic ignored_pulses();
        for (int k = 0; k < 40; k++) begin
            cfg_din = ~cfg_din;
            #3 cfg_clk = 1'b1;
            #3 cfg_clk = 1'b0;
        end
        cfg_din = 1'b0;
        @(negedge clk);
    endtask

    task automatic walk_decoder(input string req);
        for (int n = 0; n < 8; n++) begin
            in_a = DEC_VEC[n][6:4];
            in_b = DEC_VEC[n][4];
            #1 chk(req, tout, DEC_VEC[n][3:0]);
            @(negedge clk);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [39:0] s_dec, s_gate, s_cnt;
        logic        prev_par;
        logic [2:0]  prev_a;
        logic [1:0]  cnt;
        logic        x;

        // Decoder: A gives d0,d1; B sees {i0, d1, d0} and gives d2,d3.
        s_dec  = mk_stream(mk_img(8'b0001_0001, 8'b0010_0010), 2'd0, 2'd1,
                           mk_img(8'b0000_0001, 8'b0001_0000), 4'b0000);
        // Gated function: A0 = k&p&~s, A1 = registered parity; B0 = x|t, B1 = routed parity.
        s_gate = mk_stream(mk_img(8'b0100_0000, 8'b1001_0110), 2'd0, 2'd1,
                           mk_img(8'b1111_1010, 8'b1100_1100), 4'b0010);
        // Counter in B flip-flops via routes 2 and 3; A0 registered majority, A1 parity.
        s_cnt  = mk_stream(mk_img(8'b1110_1000, 8'b1001_0110), 2'd2, 2'd3,
                           mk_img(8'b0101_1010, 8'b0110_1100), 4'b1101);

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R3 R5 R4: decoder through both tables, routes 0 and 1
        load(s_dec);
        walk_decoder("R3 R5 decoder");

        // R1: configuration clock edges with load disabled are ignored
        ignored_pulses();
        walk_decoder("R1 decoder after ignored pulses");

        // R6 R2: gated function with one registered output
        in_a = 3'd0;
        in_b = 1'b0;
        load(s_gate);
        prev_par = 1'b0;
        for (int n = 0; n < 8; n++) begin
            logic [2:0] a;
            logic       t;
            a = 3'(n * 5 + 1);
            t = (n % 3) == 1;
            in_a = a;
            in_b = t;
            x = (a == 3'd6);
            #1 chk("R6 R2 gated function", tout, {prev_par, x | t, prev_par, x});
            prev_par = par3(a);
            @(negedge clk);
        end

        // R2 R4 R6 R8: counter, starts at zero after load
        in_a = 3'd0;
        in_b = 1'b0;
        load(s_cnt);
        cnt = 2'd0;
        prev_a = 3'd0;
        for (int n = 0; n < 10; n++) begin
            logic [2:0] a;
            logic       en;
            a = 3'(n * 3);
            en = (n != 2) && (n != 6);
            in_a = a;
            in_b = en;
            #1 chk("R2 R4 R6 counter", tout, {cnt, par3(a), maj3(prev_a)});
            @(negedge clk);
            if (en) cnt = cnt + 2'd1;
            prev_a = a;
        end

        // R7: synchronous reset clears state, combinational output unaffected
        in_a = 3'd7;
        in_b = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        #1 chk("R7 reset clears flip-flops", tout, 4'b0010);
        rst = 1'b0;
        @(negedge clk);
        #1 chk("R7 counting resumes after reset", tout, 4'b0111);

        // R8: reload restarts the counter from zero
        in_a = 3'd0;
        in_b = 1'b0;
        load(s_cnt);
        #1 chk("R8 reload clears counter", tout, 4'b0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule